// File: doc/BRIEF.md
# AUX Request Mailbox with Interrupt

This block is the register mailbox on the receiving side of a DisplayPort AUX channel. It sits between the AUX request receiver and an embedded controller. The receiver hands over each request as a header (command nibble, 20-bit address, length byte) followed by a stream of payload bytes and a completion strobe. The block stores them in a bank of byte registers and raises a message-ready flag. If the controller has enabled it, an interrupt line goes high.

The controller reads the request through a word-addressed register port. It then stages the reply in the same byte bank and writes the command word to start the reply. The block sends the reply command byte and the staged data bytes to the AUX transmitter over a valid/ready byte stream.

The byte bank is used in two ways. For a request, the first three registers hold the address and length, and payload byte k sits in register k+3. For a reply, data byte k comes from register k. Only one side may write the bank at a time: the receiver while the block waits for a request, and the controller while a reply is pending.

Top module: `aux_rq_mailbox`

## Requirements
- R1: The `irq` output is high exactly when the interrupt-enable bit (status word bit 3) is 1 and the message-ready flag (status word bit 1) is 1. Message-ready becomes 1 in the cycle after a `rq_done` that closes an accepted request.
- R2: The interrupt drops if the controller clears the enable bit, or if it reads the command word (address 0x100 with `cpu_rd` high). That read clears message-ready.
- R3: Status word (address 0x101) bit 0 reads 1 only from the completion of an accepted request until the reply is triggered. It reads 0 while the block waits for a request and while a reply is being sent.
- R4: Byte register i reads at address 0x102+i in bits 7:0. For a request, register 0 holds address bits 15:8, register 1 holds address bits 7:0 and register 2 holds the length byte. The command word shows the request command in bits 3:0 and address bits 19:16 in bits 19:16.
- R5: Request payload byte k is stored in register k+3. Register 17 holds payload byte 14, and payload bytes beyond the fifteenth are discarded.
- R6: A reply goes out on `tx_byte` as the reply command byte, then registers 0 to n-1, with `tx_last` marking the final byte. While `tx_ready` is low, `tx_valid` and `tx_byte` hold.
- R7: Writing the command word in the ready state sets the reply command from bits 7:0 and the reply data count n from bits 15:8. A count above 16 becomes 16. A count of 0 sends only the command byte.
- R8: Writing the command word clears message-ready and starts the reply. A command-word write while the block is not ready to reply has no effect.
- R9: A request header that arrives while a request is held or a reply is being sent is dropped and leaves the bank unchanged. It sets the overflow bit (status bit 2), which stays set until the controller writes the status word with bit 2 equal to 1.
- R10: Controller writes to the byte registers take effect only while the block is ready to reply. At other times they are ignored.
- R11: After reset, the status word, the command word, every byte register, `irq` and `tx_valid` are all 0.
- R12: When the last reply byte is accepted, the block returns to waiting and accepts the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_hdr_valid | input | 1 | Request header strobe |
| rq_cmd | input | 4 | Request command nibble |
| rq_addr | input | 20 | Request address |
| rq_len | input | 8 | Request length byte |
| rq_data_valid | input | 1 | Request payload byte strobe |
| rq_data | input | 8 | Request payload byte |
| rq_done | input | 1 | Request complete strobe |
| cpu_addr | input | AW (9) | Controller word address |
| cpu_wr | input | 1 | Controller write strobe |
| cpu_rd | input | 1 | Controller read strobe (side effects only) |
| cpu_wdata | input | DW (32) | Controller write data |
| cpu_rdata | output | DW (32) | Controller read data, combinational from address |
| irq | output | 1 | Interrupt to controller |
| tx_valid | output | 1 | Reply byte valid |
| tx_ready | input | 1 | Transmitter accepts reply byte |
| tx_byte | output | 8 | Reply byte |
| tx_last | output | 1 | Final reply byte |

## Verification
A table of four request/reply exchanges drives the main function. The exchanges cover a short request, a one-byte request with a zero-length reply and a stalling transmitter, a full fifteen-byte request with a sixteen-byte reply, and an over-long request with an over-long reply count. Together they separate correct index shifting from off-by-one placement, and truncation from clamping. Because the exchanges run back to back, they also show that the bank and the flags recover between messages. Directed cases then send a header while a request is held and while a reply is stalled, which separates dropping from overwriting. Further cases write the bank and the command word while the block waits, and clear the interrupt by the enable bit instead of by a read.

// File: rtl/amb_pkg.sv
package amb_pkg;
   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_HELD = 2'd1,
      ST_SEND = 2'd2
   } amb_state_t;

   localparam int STAT_RDY = 0;
   localparam int STAT_MSG = 1;
   localparam int STAT_OVF = 2;
   localparam int STAT_IEN = 3;
endpackage

// File: rtl/amb_bank.sv
module amb_bank
   import amb_pkg::*;
#(
   parameter int NREG = 18,
   parameter int HDR  = 3,
   parameter int IW   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  amb_state_t        st,
   input  logic              hdr_we,
   input  logic [HDR*8-1:0]  hdr_bytes,
   input  logic              rx_we,
   input  logic [IW-1:0]     rx_idx,
   input  logic [7:0]        rx_byte,
   input  logic              cpu_we,
   input  logic [IW-1:0]     cpu_idx,
   input  logic [7:0]        cpu_byte,
   input  logic [IW-1:0]     rd_idx_a,
   output logic [7:0]        rd_a,
   input  logic [IW-1:0]     rd_idx_b,
   output logic [7:0]        rd_b
);
   logic [7:0] regs_q [NREG];
   logic       rx_ok;
   logic       cpu_ok;

   // receiver owns the bank while waiting, controller while a reply is pending
   assign rx_ok  = rx_we  && (st == ST_WAIT);
   assign cpu_ok = cpu_we && (st == ST_HELD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NREG; k++) regs_q[k] <= '0;
      end else begin
         for (int k = 0; k < NREG; k++) begin
            if (k < HDR && hdr_we && st == ST_WAIT)
               regs_q[k] <= hdr_bytes[k*8 +: 8];
            else if (k >= HDR && rx_ok && int'(rx_idx) == k)
               regs_q[k] <= rx_byte;
            else if (cpu_ok && int'(cpu_idx) == k)
               regs_q[k] <= cpu_byte;
         end
      end
   end

   assign rd_a = (int'(rd_idx_a) < NREG) ? regs_q[rd_idx_a] : '0;
   assign rd_b = (int'(rd_idx_b) < NREG) ? regs_q[rd_idx_b] : '0;

   // R10: no controller write lands outside the held state
   p_cpu_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_HELD && !hdr_we && !rx_ok) |=> $stable(rd_a) || $changed(rd_idx_a));
endmodule

// File: rtl/amb_ctrl.sv
module amb_ctrl
   import amb_pkg::*;
#(
   parameter int NREG = 18,
   parameter int HDR  = 3,
   parameter int IW   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rq_hdr_valid,
   input  logic [3:0]    rq_cmd,
   input  logic [3:0]    rq_addr_hi,
   input  logic          rq_data_valid,
   input  logic          rq_done,
   input  logic          cmd_rd,
   input  logic          cmd_wr,
   input  logic          stat_wr,
   input  logic          ien_wval,
   input  logic          ovf_clr,
   input  logic          tx_done,
   output amb_state_t    st,
   output logic          msg_ready,
   output logic          ovf,
   output logic          irq_en,
   output logic          irq,
   output logic          hdr_we,
   output logic          rx_we,
   output logic [IW-1:0] rx_idx,
   output logic [3:0]    req_cmd,
   output logic [3:0]    req_addr_hi,
   output logic          tx_start
);
   localparam int PW = $clog2(NREG + 1);

   logic          rx_open_q;
   logic [PW-1:0] rx_pos_q;
   logic          drop;
   logic          accept_done;

   assign hdr_we      = rq_hdr_valid && (st == ST_WAIT);
   assign drop        = rq_hdr_valid && (st != ST_WAIT);
   assign rx_we       = rq_data_valid && rx_open_q && (int'(rx_pos_q) < NREG);
   assign rx_idx      = IW'(rx_pos_q);
   assign accept_done = rq_done && rx_open_q && (st == ST_WAIT);
   assign tx_start    = cmd_wr && (st == ST_HELD);
   assign irq         = irq_en && msg_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_WAIT;
         rx_open_q   <= 1'b0;
         rx_pos_q    <= '0;
         msg_ready   <= 1'b0;
         ovf         <= 1'b0;
         irq_en      <= 1'b0;
         req_cmd     <= '0;
         req_addr_hi <= '0;
      end else begin
         unique case (st)
            ST_WAIT: if (accept_done) st <= ST_HELD;
            ST_HELD: if (tx_start)    st <= ST_SEND;
            ST_SEND: if (tx_done)     st <= ST_WAIT;
            default:                  st <= ST_WAIT;
         endcase

         if (hdr_we)       rx_open_q <= 1'b1;
         else if (rq_done) rx_open_q <= 1'b0;

         if (hdr_we)      rx_pos_q <= PW'(HDR);
         else if (rx_we)  rx_pos_q <= rx_pos_q + 1'b1;

         if (accept_done)            msg_ready <= 1'b1;
         else if (cmd_rd || tx_start) msg_ready <= 1'b0;

         if (drop)                    ovf <= 1'b1;
         else if (stat_wr && ovf_clr) ovf <= 1'b0;

         if (stat_wr) irq_en <= ien_wval;

         if (hdr_we) begin
            req_cmd     <= rq_cmd;
            req_addr_hi <= rq_addr_hi;
         end
      end
   end

   // R1: an interrupt only ever stands for a held request
   p_irq_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (st == ST_HELD));
   // R2: reading the command word removes the interrupt
   p_cmdrd_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rd && st == ST_HELD) |=> !irq);
   // R3: ready state persists until the trigger
   p_ready_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HELD && !cmd_wr) |=> (st == ST_HELD));
   // R9: a header arriving while busy raises overflow
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> ovf);
endmodule

// File: rtl/amb_txseq.sv
module amb_txseq #(
   parameter int RPL_MAX = 16,
   parameter int IW      = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [7:0]    cmd_in,
   input  logic [7:0]    len_in,
   input  logic          tx_ready,
   input  logic [7:0]    rd_byte,
   output logic          tx_valid,
   output logic [7:0]    tx_byte,
   output logic          tx_last,
   output logic [IW-1:0] rd_idx,
   output logic          done
);
   localparam int LW = $clog2(RPL_MAX + 1);

   logic [LW-1:0] len_eff;
   logic [LW-1:0] len_q;
   logic [LW-1:0] pos_q;
   logic [7:0]    cmd_q;
   logic          active_q;

   generate
      if (RPL_MAX < 255) begin : g_clamp
         assign len_eff = (len_in > 8'(RPL_MAX)) ? LW'(RPL_MAX) : LW'(len_in);
      end else begin : g_pass
         assign len_eff = LW'(len_in);
      end
   endgenerate

   assign tx_valid = active_q;
   assign tx_last  = active_q && (pos_q == len_q);
   assign done     = tx_valid && tx_ready && tx_last;
   assign tx_byte  = (pos_q == '0) ? cmd_q : rd_byte;
   assign rd_idx   = IW'(pos_q) - IW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         pos_q    <= '0;
         len_q    <= '0;
         cmd_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         pos_q    <= '0;
         len_q    <= len_eff;
         cmd_q    <= cmd_in;
      end else if (done) begin
         active_q <= 1'b0;
         pos_q    <= '0;
      end else if (active_q && tx_ready) begin
         pos_q <= pos_q + 1'b1;
      end
   end

   // R6: a stalled byte is held
   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
   // R12: the stream ends after its last byte
   p_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !tx_valid);
   // R7: the position never passes the clamped count
   p_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (pos_q <= len_q) && (int'(len_q) <= RPL_MAX));
endmodule

// File: rtl/aux_rq_mailbox.sv
module aux_rq_mailbox
   import amb_pkg::*;
#(
   parameter int          NREG     = 18,
   parameter int          HDR      = 3,
   parameter int          RPL_MAX  = 16,
   parameter int          AW       = 9,
   parameter int          DW       = 32,
   parameter logic [8:0]  CMD_WORD = 9'h100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rq_hdr_valid,
   input  logic [3:0]    rq_cmd,
   input  logic [19:0]   rq_addr,
   input  logic [7:0]    rq_len,
   input  logic          rq_data_valid,
   input  logic [7:0]    rq_data,
   input  logic          rq_done,
   input  logic [AW-1:0] cpu_addr,
   input  logic          cpu_wr,
   input  logic          cpu_rd,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   output logic          irq,
   output logic          tx_valid,
   input  logic          tx_ready,
   output logic [7:0]    tx_byte,
   output logic          tx_last
);
   localparam int            IW         = $clog2(NREG);
   localparam logic [AW-1:0] CMD_A      = AW'(CMD_WORD);
   localparam logic [AW-1:0] STAT_A     = CMD_A + AW'(1);
   localparam logic [AW-1:0] BYTE0_A    = CMD_A + AW'(2);

   generate
      if (HDR != 3)            begin : g_bad_hdr  $error("header must occupy three registers"); end
      if (NREG < RPL_MAX)      begin : g_bad_rpl  $error("reply count exceeds bank depth");    end
      if (NREG <= HDR)         begin : g_bad_nreg $error("bank too small for header");         end
      if (RPL_MAX > 255)       begin : g_bad_max  $error("reply count must fit one byte");     end
      if (DW < 20)             begin : g_bad_dw   $error("data word too narrow");              end
      if (AW < IW)             begin : g_bad_aw   $error("address too narrow for bank");       end
   endgenerate

   amb_state_t    st;
   logic          msg_ready, ovf, irq_en;
   logic          hdr_we, rx_we, tx_start, tx_done;
   logic [IW-1:0] rx_idx, tx_idx, byte_idx;
   logic [3:0]    req_cmd, req_addr_hi;
   logic [7:0]    rd_a, rd_b;
   logic [AW-1:0] byte_off;
   logic          cmd_hit, stat_hit, byte_hit;

   assign cmd_hit  = (cpu_addr == CMD_A);
   assign stat_hit = (cpu_addr == STAT_A);
   assign byte_off = cpu_addr - BYTE0_A;
   assign byte_hit = (int'(byte_off) < NREG);
   assign byte_idx = IW'(byte_off);

   amb_ctrl #(.NREG(NREG), .HDR(HDR), .IW(IW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .rq_hdr_valid (rq_hdr_valid),
      .rq_cmd       (rq_cmd),
      .rq_addr_hi   (rq_addr[19:16]),
      .rq_data_valid(rq_data_valid),
      .rq_done      (rq_done),
      .cmd_rd       (cpu_rd && cmd_hit),
      .cmd_wr       (cpu_wr && cmd_hit),
      .stat_wr      (cpu_wr && stat_hit),
      .ien_wval     (cpu_wdata[STAT_IEN]),
      .ovf_clr      (cpu_wdata[STAT_OVF]),
      .tx_done      (tx_done),
      .st           (st),
      .msg_ready    (msg_ready),
      .ovf          (ovf),
      .irq_en       (irq_en),
      .irq          (irq),
      .hdr_we       (hdr_we),
      .rx_we        (rx_we),
      .rx_idx       (rx_idx),
      .req_cmd      (req_cmd),
      .req_addr_hi  (req_addr_hi),
      .tx_start     (tx_start)
   );

   amb_bank #(.NREG(NREG), .HDR(HDR), .IW(IW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .st       (st),
      .hdr_we   (hdr_we),
      .hdr_bytes({rq_len, rq_addr[7:0], rq_addr[15:8]}),
      .rx_we    (rx_we),
      .rx_idx   (rx_idx),
      .rx_byte  (rq_data),
      .cpu_we   (cpu_wr && byte_hit),
      .cpu_idx  (byte_idx),
      .cpu_byte (cpu_wdata[7:0]),
      .rd_idx_a (byte_idx),
      .rd_a     (rd_a),
      .rd_idx_b (tx_idx),
      .rd_b     (rd_b)
   );

   amb_txseq #(.RPL_MAX(RPL_MAX), .IW(IW)) u_txseq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (tx_start),
      .cmd_in  (cpu_wdata[7:0]),
      .len_in  (cpu_wdata[15:8]),
      .tx_ready(tx_ready),
      .rd_byte (rd_b),
      .tx_valid(tx_valid),
      .tx_byte (tx_byte),
      .tx_last (tx_last),
      .rd_idx  (tx_idx),
      .done    (tx_done)
   );

   always_comb begin
      cpu_rdata = '0;
      if (cmd_hit) begin
         cpu_rdata[3:0]   = req_cmd;
         cpu_rdata[19:16] = req_addr_hi;
      end else if (stat_hit) begin
         cpu_rdata[STAT_RDY] = (st == ST_HELD);
         cpu_rdata[STAT_MSG] = msg_ready;
         cpu_rdata[STAT_OVF] = ovf;
         cpu_rdata[STAT_IEN] = irq_en;
      end else if (byte_hit) begin
         cpu_rdata[7:0] = rd_a;
      end
   end

   logic unused_wdata;
   assign unused_wdata = &{1'b0, cpu_wdata[DW-1:16]};

   // R3: ready status and an active reply never overlap
   p_ready_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HELD) |-> !tx_valid);
   // R8: a trigger outside the ready state starts nothing
   p_trig_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cmd_hit && st == ST_WAIT) |=> !tx_valid);
endmodule

// File: tb/aux_rq_mailbox_bench.sv
module aux_rq_mailbox_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rq_hdr_valid = 0, rq_data_valid = 0, rq_done = 0;
   logic [3:0]  rq_cmd = '0;
   logic [19:0] rq_addr = '0;
   logic [7:0]  rq_len = '0, rq_data = '0;
   logic [8:0]  cpu_addr = '0;
   logic        cpu_wr = 0, cpu_rd = 0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        irq, tx_valid, tx_last;
   logic        tx_ready = 0;
   logic [7:0]  tx_byte;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] rv;

   localparam logic [8:0] A_CMD  = 9'h100;
   localparam logic [8:0] A_STAT = 9'h101;
   localparam logic [8:0] A_BYTE = 9'h102;

   // cmd, addr, len, payload count, payload seed, reply count
   localparam logic [52:0] VEC [0:3] = '{
      {4'h9, 20'h12345, 8'h03, 5'd4,  8'h10, 8'd4},
      {4'h4, 20'hA00FF, 8'h00, 5'd1,  8'h80, 8'd0},
      {4'h1, 20'h0F0F0, 8'h0E, 5'd15, 8'hC0, 8'd16},
      {4'h5, 20'h7ABCD, 8'h0F, 5'd17, 8'h20, 8'd40}
   };

   always #2 clk = ~clk;

   aux_rq_mailbox u_aux_rq_mailbox (
      .clk(clk), .rst_n(rst_n),
      .rq_hdr_valid(rq_hdr_valid), .rq_cmd(rq_cmd), .rq_addr(rq_addr), .rq_len(rq_len),
      .rq_data_valid(rq_data_valid), .rq_data(rq_data), .rq_done(rq_done),
      .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_byte(tx_byte), .tx_last(tx_last)
   );

   function automatic logic [7:0] rbyte(input int v, input int i);
      return 8'((v * 37) + (i * 5) + 17);
   endfunction

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, input bit strobe);
      @(negedge clk);
      cpu_addr = a; cpu_rd = strobe;
      #1 rv = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   task automatic send_req(input logic [3:0] c, input logic [19:0] a, input logic [7:0] l,
                           input int n, input logic [7:0] seed);
      @(negedge clk);
      rq_hdr_valid = 1'b1; rq_cmd = c; rq_addr = a; rq_len = l;
      @(negedge clk);
      rq_hdr_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         rq_data_valid = 1'b1; rq_data = 8'(seed + k);
         @(negedge clk);
      end
      rq_data_valid = 1'b0;
      rq_done = 1'b1;
      @(negedge clk);
      rq_done = 1'b0;
   endtask

   task automatic take_reply(input logic [7:0] ecmd, input int elen, input int v, input bit stall);
      int got = 0;
      bit fin = 0;
      int guard = 0;
      while (!fin && guard < 200) begin
         @(negedge clk);
         guard++;
         tx_ready = stall ? (guard % 2 == 0) : 1'b1;
         #1;
         if (tx_valid && tx_ready) begin
            chk("R6 reply byte", {24'h0, tx_byte}, {24'h0, (got == 0) ? ecmd : rbyte(v, got - 1)});
            chk("R6 last flag", {31'h0, tx_last}, {31'h0, got == elen});
            if (tx_last) fin = 1;
            got++;
         end
      end
      @(negedge clk);
      tx_ready = 1'b0;
      chk("R7 reply length", got, elen + 1);
   endtask

   logic [3:0]  v_cmd;
   logic [19:0] v_addr;
   logic [7:0]  v_len, v_seed, v_rlen;
   int          v_n, v_kept, v_elen;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 irq after reset", {31'h0, irq}, 32'h0);
      chk("R11 tx_valid after reset", {31'h0, tx_valid}, 32'h0);
      rd(A_STAT, 0); chk("R11 status after reset", rv, 32'h0);
      rd(A_CMD, 0);  chk("R11 command after reset", rv, 32'h0);
      rd(A_BYTE + 9'd5, 0); chk("R11 byte after reset", rv, 32'h0);
      wr(A_STAT, 32'h8);
      rd(A_STAT, 0); chk("R1 enable bit", rv, 32'h8);

      for (int v = 0; v < 4; v++) begin
         {v_cmd, v_addr, v_len, v_n, v_seed, v_rlen} = {VEC[v][52:21], 27'(VEC[v][20:16]), VEC[v][15:0]};
         v_n    = int'(VEC[v][20:16]);
         v_kept = (v_n > 15) ? 15 : v_n;
         v_elen = (v_rlen > 8'd16) ? 16 : int'(v_rlen);
         send_req(v_cmd, v_addr, v_len, v_n, v_seed);
         chk("R1 irq on message", {31'h0, irq}, 32'h1);
         rd(A_STAT, 0); chk("R3 status held", rv, 32'hB);
         rd(A_CMD, 1);
         chk("R4 command word", rv, {12'h0, v_addr[19:16], 12'h0, v_cmd});
         chk("R2 irq after command read", {31'h0, irq}, 32'h0);
         rd(A_STAT, 0); chk("R2 message flag cleared", rv, 32'h9);
         rd(A_BYTE, 0);        chk("R4 reg0 addr hi", rv, {24'h0, v_addr[15:8]});
         rd(A_BYTE + 9'd1, 0); chk("R4 reg1 addr lo", rv, {24'h0, v_addr[7:0]});
         rd(A_BYTE + 9'd2, 0); chk("R4 reg2 length", rv, {24'h0, v_len});
         for (int k = 0; k < v_kept; k++) begin
            rd(A_BYTE + 9'(k + 3), 0);
            chk("R5 payload shift", rv, {24'h0, 8'(v_seed + k)});
         end
         if (v_n > 15) begin
            rd(A_BYTE + 9'd17, 0);
            chk("R5 reg17 holds payload 14", rv, {24'h0, 8'(v_seed + 14)});
         end
         for (int i = 0; i < 16; i++) wr(A_BYTE + 9'(i), {24'h0, rbyte(v, i)});
         wr(A_CMD, {16'h0, v_rlen, 8'(8'hA0 + v)});
         chk("R8 reply started", {31'h0, tx_valid}, 32'h1);
         rd(A_STAT, 0); chk("R3 status while sending", rv, 32'h8);
         take_reply(8'(8'hA0 + v), v_elen, v, v == 1);
         rd(A_STAT, 0); chk("R12 back to waiting", rv, 32'h8);
      end

      // R10: bank writes while waiting are ignored
      wr(A_BYTE, 32'h77);
      rd(A_BYTE, 0); chk("R10 write ignored while waiting", rv, {24'h0, rbyte(3, 0)});
      // R8: trigger while waiting is ignored
      wr(A_CMD, 32'h0301);
      chk("R8 trigger ignored", {31'h0, tx_valid}, 32'h0);
      rd(A_STAT, 0); chk("R8 status after ignored trigger", rv, 32'h8);

      // R9: header while held is dropped
      send_req(4'h2, 20'h34455, 8'h01, 2, 8'h60);
      send_req(4'h7, 20'h99999, 8'h05, 3, 8'hE0);
      rd(A_STAT, 0); chk("R9 overflow while held", rv, 32'hF);
      rd(A_BYTE, 0); chk("R9 reg0 kept", rv, 32'h44);
      rd(A_BYTE + 9'd3, 0); chk("R9 payload kept", rv, 32'h60);
      rd(A_CMD, 0); chk("R9 command kept", rv, 32'h30002);
      wr(A_STAT, 32'hC);
      rd(A_STAT, 0); chk("R9 overflow cleared", rv, 32'hB);
      chk("R1 irq pending", {31'h0, irq}, 32'h1);
      wr(A_STAT, 32'h0);
      chk("R2 irq after disable", {31'h0, irq}, 32'h0);
      rd(A_STAT, 0); chk("R2 message still set", rv, 32'h3);
      wr(A_CMD, 32'h0000_00C3);
      rd(A_STAT, 0); chk("R8 trigger clears message", rv, 32'h0);
      send_req(4'h6, 20'h11111, 8'h00, 1, 8'h55);
      rd(A_STAT, 0); chk("R9 overflow while sending", rv, 32'h4);
      chk("R6 stalled byte", {23'h0, tx_valid, tx_byte}, {23'h0, 1'b1, 8'hC3});
      chk("R7 zero count last", {31'h0, tx_last}, 32'h1);
      take_reply(8'hC3, 0, 0, 0);
      rd(A_STAT, 0); chk("R9 overflow sticky", rv, 32'h4);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule